// File: doc/BRIEF.md
# Out-of-Order Instruction Window with In-Order Retirement

This block holds renamed instructions between decode and retirement. Decode writes instructions into a circular window in program order and receives the slot index as the instruction's tag. An instruction's source operands come either as values, or as tags of older in-flight producers. A small rename map tracks, for each architectural register, the tag of its newest in-flight producer.

Finished functional units broadcast a tag, a result value and an exception cause on a shared result bus. Every waiting operand that names that tag takes the value. Any entry whose operands are both present can be sent to the functional units. One entry is sent per cycle, and the oldest ready entry wins. Entries retire strictly in program order from the head of the window and write the architectural register file.

A head entry that finished with a nonzero cause does not write the register file. It signals an exception and empties the whole window. It also forgets every rename mapping, so that decode then reads the committed register file.

Top module: `reorder_window`

## Requirements
- R1: After reset the window is empty: `full` is 0, `allocReady` is 1, `allocTag` is 0, and neither `dispValid`, `cmtValid` nor `cmtExc` is asserted.
- R2: An accepted allocation takes the slot shown on `allocTag`. The next allocation gets the next slot, wrapping from DEPTH-1 to 0.
- R3: At allocation, each source is resolved in one of three ways. A register with no in-flight producer takes the value that decode supplies. A producer that has already finished supplies its result value. Any other producer leaves the source waiting on the producer's tag.
- R4: When `resValid` is high, every waiting source in the window whose tag equals `resTag` takes `resData` and becomes present.
- R5: A source that is allocated waiting on a tag in the same cycle that the tag is broadcast captures the broadcast value at once.
- R6: An entry is eligible to dispatch when it is occupied, not yet dispatched, and has both operands present. At most one entry dispatches per cycle: the eligible entry nearest to the head, counting forward circularly. A dispatched entry is never dispatched again.
- R7: The head entry retires only after its result has arrived. On retirement `cmtValid` pulses with the entry's destination register and result data, and the head advances by one slot. Younger finished entries wait behind an unfinished head.
- R8: Retirement clears a register's rename mapping only if the mapping still names the retiring tag. A newer in-flight producer of the same register stays mapped.
- R9: `full` is 1 exactly when DEPTH entries are occupied. An allocation request while full changes no entry, no pointer and no count.
- R10: A finished head entry with a nonzero cause raises `cmtExc` with `cmtCause` and leaves `cmtValid` at 0. No entry dispatches in that cycle. On the following cycle the window is empty, the allocate pointer equals the head pointer, and no register has a rename mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Decode presents an instruction |
| allocOp | input | OP_W | Opcode of the instruction |
| allocSrc1 | input | REG_W | First source register |
| allocSrc2 | input | REG_W | Second source register |
| allocDest | input | REG_W | Destination register |
| allocVal1 | input | DATA_W | Committed value of the first source register |
| allocVal2 | input | DATA_W | Committed value of the second source register |
| allocReady | output | 1 | Allocation is accepted this cycle if requested |
| allocTag | output | TAG_W | Tag given to the instruction being allocated |
| full | output | 1 | Every slot is occupied |
| dispValid | output | 1 | An entry is sent to the functional units |
| dispTag | output | TAG_W | Tag of the dispatched entry |
| dispOp | output | OP_W | Opcode of the dispatched entry |
| dispOpnd1 | output | DATA_W | First operand value |
| dispOpnd2 | output | DATA_W | Second operand value |
| resValid | input | 1 | Result broadcast valid |
| resTag | input | TAG_W | Tag of the finished instruction |
| resData | input | DATA_W | Result value |
| resCause | input | CAUSE_W | Exception cause, zero for none |
| cmtValid | output | 1 | Head entry retires and writes the register file |
| cmtReg | output | REG_W | Destination register of the retiring entry |
| cmtData | output | DATA_W | Value written to the register file |
| cmtExc | output | 1 | Head entry raised an exception; the window is flushed |
| cmtCause | output | CAUSE_W | Cause of the head entry |

## Verification
Allocation can coincide with a result broadcast, and retirement can coincide with a new allocation to the same destination register. The stimulus table drives both cases. In the first, a new instruction names a producer whose result appears on the bus in that same cycle. The bench judges this by the operand value sent when the consumer later dispatches. In the second, a register's producer retires while a younger writer of that register is allocated. A following consumer of the register must then wait on the younger tag and must not read the committed value, and its dispatched operands confirm which path was taken.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // strobes the control sends to the entry datapath each cycle
  typedef struct packed {
    logic alloc;
    logic disp;
    logic commit;
    logic flush;
  } robStrobes_t;

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocValid,
  input  logic [DEPTH-1:0] readyVec,
  input  logic [DEPTH-1:0] useVec,
  input  logic [DEPTH-1:0] doneVec,
  input  logic [DEPTH-1:0] excVec,
  output robStrobes_t      strb,
  output logic [TAG_W-1:0] allocIdx,
  output logic [TAG_W-1:0] dispIdx,
  output logic [TAG_W-1:0] headIdx,
  output logic             full,
  output logic             allocReady
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] allocPtr;
  logic [TAG_W-1:0] cmtPtr;
  logic [CNT_W-1:0] count;
  logic             anyReady;
  logic             headFinished;

  function automatic logic [TAG_W-1:0] nextPtr(input logic [TAG_W-1:0] p);
    if (p == TAG_W'(DEPTH - 1)) return '0;
    return p + TAG_W'(1);
  endfunction

  assign allocIdx     = allocPtr;
  assign headIdx      = cmtPtr;
  assign full         = (count == CNT_W'(DEPTH));
  assign headFinished = useVec[cmtPtr] && doneVec[cmtPtr];

  // scan forward from the head so the oldest ready entry wins
  always_comb begin
    int j;
    anyReady = 1'b0;
    dispIdx  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      j = int'(cmtPtr) + i;
      if (j >= DEPTH) j = j - DEPTH;
      if (!anyReady && readyVec[TAG_W'(j)]) begin
        anyReady = 1'b1;
        dispIdx  = TAG_W'(j);
      end
    end
  end

  always_comb begin
    strb.flush  = headFinished && excVec[cmtPtr];
    strb.commit = headFinished && !excVec[cmtPtr];
    strb.disp   = anyReady && !strb.flush;
    strb.alloc  = allocValid && !full && !strb.flush;
    allocReady  = !full && !strb.flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      allocPtr <= '0;
      cmtPtr   <= '0;
      count    <= '0;
    end else if (strb.flush) begin
      allocPtr <= cmtPtr;
      count    <= '0;
    end else begin
      if (strb.alloc)  allocPtr <= nextPtr(allocPtr);
      if (strb.commit) cmtPtr   <= nextPtr(cmtPtr);
      case ({strb.alloc, strb.commit})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R2
  alloc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.alloc |=> allocPtr == nextPtr($past(allocPtr)));

  // R7
  commit_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> cmtPtr == nextPtr($past(cmtPtr)));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R10
  flush_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (allocPtr == cmtPtr) && (count == '0));

endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int NREGS   = 8,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 4,
  parameter int CAUSE_W = 4,
  localparam int TAG_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int REG_W  = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  robStrobes_t        strb,
  input  logic [TAG_W-1:0]   allocIdx,
  input  logic [TAG_W-1:0]   dispIdx,
  input  logic [TAG_W-1:0]   headIdx,
  input  logic [OP_W-1:0]    allocOp,
  input  logic [REG_W-1:0]   allocSrc1,
  input  logic [REG_W-1:0]   allocSrc2,
  input  logic [REG_W-1:0]   allocDest,
  input  logic [DATA_W-1:0]  allocVal1,
  input  logic [DATA_W-1:0]  allocVal2,
  input  logic               resValid,
  input  logic [TAG_W-1:0]   resTag,
  input  logic [DATA_W-1:0]  resData,
  input  logic [CAUSE_W-1:0] resCause,
  output logic [DEPTH-1:0]   readyVec,
  output logic [DEPTH-1:0]   useVec,
  output logic [DEPTH-1:0]   doneVec,
  output logic [DEPTH-1:0]   excVec,
  output logic [OP_W-1:0]    dispOp,
  output logic [DATA_W-1:0]  dispOpnd1,
  output logic [DATA_W-1:0]  dispOpnd2,
  output logic [REG_W-1:0]   headDest,
  output logic [DATA_W-1:0]  headData,
  output logic [CAUSE_W-1:0] headCause
);

  // a source field holds either a value or a producer tag
  localparam int SRC_W = (DATA_W >= TAG_W) ? DATA_W : TAG_W;

  logic [DEPTH-1:0]   useQ, execQ, pdQ, p1Q, p2Q;
  logic [OP_W-1:0]    opQ    [DEPTH];
  logic [REG_W-1:0]   destQ  [DEPTH];
  logic [SRC_W-1:0]   src1Q  [DEPTH];
  logic [SRC_W-1:0]   src2Q  [DEPTH];
  logic [DATA_W-1:0]  dataQ  [DEPTH];
  logic [CAUSE_W-1:0] causeQ [DEPTH];

  logic [NREGS-1:0]   renValid;
  logic [TAG_W-1:0]   renTag [NREGS];

  // rename lookup, one port per source operand
  logic [REG_W-1:0]   lkReg  [2];
  logic [DATA_W-1:0]  lkVal  [2];
  logic [TAG_W-1:0]   lkTag  [2];
  logic               lkPres [2];
  logic [SRC_W-1:0]   lkSrc  [2];

  assign lkReg[0] = allocSrc1;
  assign lkReg[1] = allocSrc2;
  assign lkVal[0] = allocVal1;
  assign lkVal[1] = allocVal2;

  for (genvar s = 0; s < 2; s++) begin : g_lookup
    assign lkTag[s] = renTag[lkReg[s]];
    always_comb begin
      lkPres[s] = 1'b1;
      lkSrc[s]  = SRC_W'(lkVal[s]);
      if (renValid[lkReg[s]]) begin
        if (pdQ[lkTag[s]]) begin
          lkSrc[s] = SRC_W'(dataQ[lkTag[s]]);
        end else if (resValid && resTag == lkTag[s]) begin
          lkSrc[s] = SRC_W'(resData);
        end else begin
          lkPres[s] = 1'b0;
          lkSrc[s]  = SRC_W'(lkTag[s]);
        end
      end
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_flags
    assign readyVec[e] = useQ[e] && !execQ[e] && p1Q[e] && p2Q[e];
    assign excVec[e]   = (causeQ[e] != '0);
  end

  assign useVec    = useQ;
  assign doneVec   = pdQ & useQ;
  assign dispOp    = opQ[dispIdx];
  assign dispOpnd1 = src1Q[dispIdx][DATA_W-1:0];
  assign dispOpnd2 = src2Q[dispIdx][DATA_W-1:0];
  assign headDest  = destQ[headIdx];
  assign headData  = dataQ[headIdx];
  assign headCause = causeQ[headIdx];

  // entry storage: wakeup, completion, retire, dispatch, then allocation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      useQ  <= '0;
      execQ <= '0;
      pdQ   <= '0;
      p1Q   <= '0;
      p2Q   <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        opQ[e]    <= '0;
        destQ[e]  <= '0;
        src1Q[e]  <= '0;
        src2Q[e]  <= '0;
        dataQ[e]  <= '0;
        causeQ[e] <= '0;
      end
    end else if (strb.flush) begin
      useQ <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (resValid && useQ[e] && !p1Q[e] && src1Q[e][TAG_W-1:0] == resTag) begin
          p1Q[e]   <= 1'b1;
          src1Q[e] <= SRC_W'(resData);
        end
        if (resValid && useQ[e] && !p2Q[e] && src2Q[e][TAG_W-1:0] == resTag) begin
          p2Q[e]   <= 1'b1;
          src2Q[e] <= SRC_W'(resData);
        end
        if (resValid && resTag == TAG_W'(e)) begin
          pdQ[e]    <= 1'b1;
          dataQ[e]  <= resData;
          causeQ[e] <= resCause;
        end
        if (strb.commit && headIdx == TAG_W'(e)) useQ[e] <= 1'b0;
        if (strb.disp && dispIdx == TAG_W'(e)) execQ[e] <= 1'b1;
        if (strb.alloc && allocIdx == TAG_W'(e)) begin
          useQ[e]   <= 1'b1;
          execQ[e]  <= 1'b0;
          pdQ[e]    <= 1'b0;
          opQ[e]    <= allocOp;
          destQ[e]  <= allocDest;
          p1Q[e]    <= lkPres[0];
          src1Q[e]  <= lkSrc[0];
          p2Q[e]    <= lkPres[1];
          src2Q[e]  <= lkSrc[1];
          causeQ[e] <= '0;
        end
      end
    end
  end

  // rename map: retire clears a stale mapping, a new allocation overrides
  always_ff @(posedge clk) begin
    if (!rstN) begin
      renValid <= '0;
      for (int r = 0; r < NREGS; r++) renTag[r] <= '0;
    end else if (strb.flush) begin
      renValid <= '0;
    end else begin
      if (strb.commit && renValid[headDest] && renTag[headDest] == headIdx)
        renValid[headDest] <= 1'b0;
      if (strb.alloc) begin
        renValid[allocDest] <= 1'b1;
        renTag[allocDest]   <= allocIdx;
      end
    end
  end

  // R6
  disp_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.disp |-> (useQ[dispIdx] && !execQ[dispIdx] && p1Q[dispIdx] && p2Q[dispIdx]));

  // R6
  no_redispatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.disp |=> execQ[$past(dispIdx)]);

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (useQ == '0) && (renValid == '0));

  // R7
  commit_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> (useQ[headIdx] && pdQ[headIdx]));

endmodule

// File: rtl/reorder_window.sv
module reorder_window
  import rob_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int NREGS   = 8,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 4,
  parameter int CAUSE_W = 4,
  localparam int TAG_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int REG_W  = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocValid,
  input  logic [OP_W-1:0]    allocOp,
  input  logic [REG_W-1:0]   allocSrc1,
  input  logic [REG_W-1:0]   allocSrc2,
  input  logic [REG_W-1:0]   allocDest,
  input  logic [DATA_W-1:0]  allocVal1,
  input  logic [DATA_W-1:0]  allocVal2,
  output logic               allocReady,
  output logic [TAG_W-1:0]   allocTag,
  output logic               full,
  output logic               dispValid,
  output logic [TAG_W-1:0]   dispTag,
  output logic [OP_W-1:0]    dispOp,
  output logic [DATA_W-1:0]  dispOpnd1,
  output logic [DATA_W-1:0]  dispOpnd2,
  input  logic               resValid,
  input  logic [TAG_W-1:0]   resTag,
  input  logic [DATA_W-1:0]  resData,
  input  logic [CAUSE_W-1:0] resCause,
  output logic               cmtValid,
  output logic [REG_W-1:0]   cmtReg,
  output logic [DATA_W-1:0]  cmtData,
  output logic               cmtExc,
  output logic [CAUSE_W-1:0] cmtCause
);

  robStrobes_t      strb;
  logic [TAG_W-1:0] allocIdx, dispIdx, headIdx;
  logic [DEPTH-1:0] readyVec, useVec, doneVec, excVec;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .allocValid (allocValid),
    .readyVec   (readyVec),
    .useVec     (useVec),
    .doneVec    (doneVec),
    .excVec     (excVec),
    .strb       (strb),
    .allocIdx   (allocIdx),
    .dispIdx    (dispIdx),
    .headIdx    (headIdx),
    .full       (full),
    .allocReady (allocReady)
  );

  rob_data #(
    .DEPTH(DEPTH), .NREGS(NREGS), .DATA_W(DATA_W), .OP_W(OP_W), .CAUSE_W(CAUSE_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .allocIdx  (allocIdx),
    .dispIdx   (dispIdx),
    .headIdx   (headIdx),
    .allocOp   (allocOp),
    .allocSrc1 (allocSrc1),
    .allocSrc2 (allocSrc2),
    .allocDest (allocDest),
    .allocVal1 (allocVal1),
    .allocVal2 (allocVal2),
    .resValid  (resValid),
    .resTag    (resTag),
    .resData   (resData),
    .resCause  (resCause),
    .readyVec  (readyVec),
    .useVec    (useVec),
    .doneVec   (doneVec),
    .excVec    (excVec),
    .dispOp    (dispOp),
    .dispOpnd1 (dispOpnd1),
    .dispOpnd2 (dispOpnd2),
    .headDest  (cmtReg),
    .headData  (cmtData),
    .headCause (cmtCause)
  );

  assign allocTag  = allocIdx;
  assign dispValid = strb.disp;
  assign dispTag   = dispIdx;
  assign cmtValid  = strb.commit;
  assign cmtExc    = strb.flush;

endmodule

// File: tb/tb_reorder_window.sv
module tb_reorder_window;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        allocValid = 1'b0;
  logic [3:0]  allocOp = '0;
  logic [2:0]  allocSrc1 = '0, allocSrc2 = '0, allocDest = '0;
  logic [15:0] allocVal1 = '0, allocVal2 = '0;
  logic        allocReady, full;
  logic [2:0]  allocTag;
  logic        dispValid;
  logic [2:0]  dispTag;
  logic [3:0]  dispOp;
  logic [15:0] dispOpnd1, dispOpnd2;
  logic        resValid = 1'b0;
  logic [2:0]  resTag = '0;
  logic [15:0] resData = '0;
  logic [3:0]  resCause = '0;
  logic        cmtValid, cmtExc;
  logic [2:0]  cmtReg;
  logic [15:0] cmtData;
  logic [3:0]  cmtCause;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  reorder_window dut (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocOp(allocOp), .allocSrc1(allocSrc1),
    .allocSrc2(allocSrc2), .allocDest(allocDest), .allocVal1(allocVal1),
    .allocVal2(allocVal2), .allocReady(allocReady), .allocTag(allocTag),
    .full(full), .dispValid(dispValid), .dispTag(dispTag), .dispOp(dispOp),
    .dispOpnd1(dispOpnd1), .dispOpnd2(dispOpnd2), .resValid(resValid),
    .resTag(resTag), .resData(resData), .resCause(resCause),
    .cmtValid(cmtValid), .cmtReg(cmtReg), .cmtData(cmtData),
    .cmtExc(cmtExc), .cmtCause(cmtCause)
  );

  typedef struct packed {
    logic        aV;
    logic [3:0]  op;
    logic [2:0]  s1, s2, dst;
    logic [15:0] v1, v2;
    logic        rV;
    logic [2:0]  rTag;
    logic [15:0] rData;
    logic [2:0]  eATag;
    logic        eDisp;
    logic [2:0]  eDTag;
    logic [15:0] eD1, eD2;
    logic        eCmt;
    logic [2:0]  eCReg;
    logic [15:0] eCData;
  } stepT;

  // each row: inputs for one cycle and the outputs expected before its edge
  localparam stepT STEPS [12] = '{
    '{1,1,1,2,3,10,20, 0,0,0,  0, 0,0,0,0,    0,0,0},   // R3 plain values
    '{1,2,3,1,4,0,5,   0,0,0,  1, 1,0,10,20,  0,0,0},   // R3 src1 waits on tag0
    '{0,0,0,0,0,0,0,   1,0,30, 2, 0,0,0,0,    0,0,0},   // R4 broadcast tag0
    '{1,3,3,4,3,0,0,   0,0,0,  2, 1,1,30,5,   1,3,30},  // R3 done producer, R8 realloc r3
    '{1,4,4,0,5,0,7,   1,1,35, 3, 0,0,0,0,    0,0,0},   // R5 same-cycle capture
    '{0,0,0,0,0,0,0,   0,0,0,  4, 1,2,30,35,  1,4,35},  // R6 oldest of two ready
    '{1,5,4,3,6,99,0,  0,0,0,  4, 1,3,35,7,   0,0,0},   // R8 r4 cleared, r3 still mapped
    '{0,0,0,0,0,0,0,   1,3,50, 5, 0,0,0,0,    0,0,0},   // R7 younger finishes first
    '{0,0,0,0,0,0,0,   1,2,60, 5, 0,0,0,0,    0,0,0},
    '{0,0,0,0,0,0,0,   0,0,0,  5, 1,4,99,60,  1,3,60},
    '{0,0,0,0,0,0,0,   1,4,1,  5, 0,0,0,0,    1,5,50},
    '{0,0,0,0,0,0,0,   0,0,0,  5, 0,0,0,0,    1,6,1}
  };

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic driveAlloc(input logic v, input logic [3:0] op, input logic [2:0] s1,
                            input logic [2:0] s2, input logic [2:0] d,
                            input logic [15:0] a, input logic [15:0] b);
    allocValid = v; allocOp = op; allocSrc1 = s1; allocSrc2 = s2;
    allocDest = d; allocVal1 = a; allocVal2 = b;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 full", full, 0);
    chk("R1 allocReady", allocReady, 1);
    chk("R1 allocTag", allocTag, 0);
    chk("R1 dispValid", dispValid, 0);
    chk("R1 cmtValid", cmtValid, 0);
    chk("R1 cmtExc", cmtExc, 0);
    @(negedge clk);

    for (int k = 0; k < 12; k++) begin
      driveAlloc(STEPS[k].aV, STEPS[k].op, STEPS[k].s1, STEPS[k].s2,
                 STEPS[k].dst, STEPS[k].v1, STEPS[k].v2);
      resValid = STEPS[k].rV; resTag = STEPS[k].rTag;
      resData = STEPS[k].rData; resCause = '0;
      #1;
      chk("R2 allocTag", allocTag, STEPS[k].eATag);
      chk("R6 dispValid", dispValid, STEPS[k].eDisp);
      if (STEPS[k].eDisp) begin
        chk("R6 dispTag", dispTag, STEPS[k].eDTag);
        chk("R3 R4 R5 dispOpnd1", dispOpnd1, STEPS[k].eD1);
        chk("R3 R4 R5 dispOpnd2", dispOpnd2, STEPS[k].eD2);
      end
      chk("R7 cmtValid", cmtValid, STEPS[k].eCmt);
      if (STEPS[k].eCmt) begin
        chk("R7 cmtReg", cmtReg, STEPS[k].eCReg);
        chk("R7 cmtData", cmtData, STEPS[k].eCData);
      end
      chk("R10 cmtExc idle", cmtExc, 0);
      @(negedge clk);
    end
    driveAlloc(0, 0, 0, 0, 0, 0, 0);
    resValid = 1'b0;
    #1;
    chk("R7 empty no commit", cmtValid, 0);
    chk("R9 not full", full, 0);

    // fill all slots from tag 5, wrapping; each is ready the cycle after it
    for (int k = 0; k < 8; k++) begin
      driveAlloc(1, 4'(k), 0, 0, 7, 16'(k), 0);
      #1;
      chk("R2 wrap allocTag", allocTag, (5 + k) % 8);
      if (k >= 1) begin
        chk("R6 oldest dispValid", dispValid, 1);
        chk("R6 oldest dispTag", dispTag, (5 + k - 1) % 8);
        chk("R6 oldest dispOp", dispOp, k - 1);
      end
      @(negedge clk);
    end
    // R9 request while full is ignored
    driveAlloc(1, 15, 0, 0, 2, 555, 0);
    #1;
    chk("R9 full", full, 1);
    chk("R9 allocReady", allocReady, 0);
    chk("R6 last dispTag", dispTag, 4);
    @(negedge clk);
    driveAlloc(0, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R9 still full", full, 1);
    chk("R9 no redispatch of head", dispValid, 0);
    chk("R9 allocTag", allocTag, 5);

    // R10 head finishes with an exception cause
    resValid = 1'b1; resTag = 5; resData = 16'h00aa; resCause = 4'd3;
    @(negedge clk);
    resValid = 1'b0; resCause = '0;
    #1;
    chk("R10 cmtExc", cmtExc, 1);
    chk("R10 cmtCause", cmtCause, 3);
    chk("R10 cmtValid low", cmtValid, 0);
    chk("R10 no dispatch", dispValid, 0);
    chk("R10 allocReady low", allocReady, 0);
    @(negedge clk);
    #1;
    chk("R10 cmtExc cleared", cmtExc, 0);
    chk("R10 not full", full, 0);
    chk("R10 allocReady", allocReady, 1);
    chk("R10 allocTag = head", allocTag, 5);
    chk("R10 window empty", dispValid, 0);
    // r7 was mapped to flushed entries; it must read the supplied value now
    driveAlloc(1, 9, 7, 0, 1, 77, 8);
    @(negedge clk);
    driveAlloc(0, 0, 0, 0, 0, 0, 0);
    #1;
    chk("R10 dispValid after flush", dispValid, 1);
    chk("R10 dispTag", dispTag, 5);
    chk("R10 rename cleared opnd1", dispOpnd1, 77);
    chk("R10 opnd2", dispOpnd2, 8);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule